// File: doc/BRIEF.md
# Track Format Byte Generator

This block produces the raw byte stream that formats one track of a double-density floppy disk. Each run starts with a `start_i` pulse. The pulse captures three values: the number of sectors on the track, the length of the gap that ends each sector, and the fill byte. The block then sends the track preamble: gaps, sync bytes and the index mark. After the preamble it asks the host for four ID bytes per sector, in the order cylinder, head, record, size code.

When the size code byte of a sector arrives, the block sends that whole sector. The sector holds sync bytes, an address mark, the ID field and its CRC, a gap, a second sync run, a data mark, the fill data and a data CRC, and it ends with the trailing gap. The output uses a valid/ready handshake.

Each output byte carries a flag that marks the special sync bytes. A downstream modulation encoder uses this flag to drop clock bits on those bytes. After the last sector the block raises `done_o` and holds it until the next start.

Top module: `trk_fmt_gen`

## Requirements
- R1: After reset, `out_valid_o`, `id_ready_o` and `done_o` are all low.
- R2: A start taken while idle or done is followed by the preamble: 80 bytes 0x4E, 12 bytes 0x00, 3 bytes 0xC2, one 0xFC, then 50 bytes 0x4E. The first preamble byte is valid in the cycle after the start.
- R3: Each sector begins with 12 bytes 0x00, 3 bytes 0xA1 and the byte 0xFE. These are followed by the four host ID bytes in the order received, then a 2-byte ID CRC. After the CRC come 22 bytes 0x4E and 12 bytes 0x00.
- R4: After the second sync run come 3 bytes 0xA1, the byte 0xFB, and then 128<<(N & 7) copies of the fill byte. N is the fourth ID byte of the sector, so N=2 and N=10 both give 512 bytes. A 2-byte data CRC follows.
- R5: Each sector ends with exactly gap-length bytes 0x4E. A gap length of zero sends none.
- R6: Both CRCs use the CCITT polynomial 0x1021, are preset to 0xFFFF, process each byte MSB first and are sent high byte first. The ID CRC covers the three 0xA1 bytes through N. The data CRC covers the three 0xA1 bytes, the 0xFB and all fill bytes.
- R7: `out_mark_o` is high exactly on the 0xC2 preamble bytes and on the 0xA1 mark bytes, and low on every other byte.
- R8: `id_ready_o` is high only while the block waits for ID bytes and never while a byte is being offered. An ID byte offered at any other time is not taken and does not change the stream.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the byte and its mark flag stay unchanged.
- R10: After the last byte of sector number sectors-per-track, or straight after the preamble when that count is 0, `done_o` goes high with no further bytes. A start is ignored while a track is in progress, and a new start clears `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a track; captures the three settings below |
| spt_i | input | 8 | Sectors on the track |
| gap3_i | input | 8 | Trailing gap length per sector |
| fill_i | input | 8 | Data field fill byte |
| id_valid_i | input | 1 | Host ID byte valid |
| id_data_i | input | 8 | Host ID byte (C, H, R, N order) |
| id_ready_o | output | 1 | Block accepts an ID byte |
| out_valid_o | output | 1 | Stream byte valid |
| out_ready_i | input | 1 | Downstream accepts the byte |
| out_data_o | output | 8 | Stream byte |
| out_mark_o | output | 1 | Byte is a sync mark (0xC2 or 0xA1) |
| done_o | output | 1 | Track complete |

## Verification
The hardest cases to reach are a downstream stall that lands inside a CRC pair or on a mark byte, combined with host traffic at the wrong moment. That traffic is an ID byte offered while a sector is still being sent, or a second start in mid-track. To reach them, the bench throttles the output ready signal at random and keeps a junk ID byte valid throughout emission on the disturbed runs. It also pulses start with different settings partway through the preamble, and then compares the whole stream region by region with an independently built image. Directed runs cover a zero gap, a zero sector count, a size code above 7 and the largest 16 KiB data field.

// File: rtl/trk_fmt_pkg.sv
package trk_fmt_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_HGAP, ST_HSYNC, ST_HMARK, ST_HIAM, ST_HGAP1, ST_WAIT,
    ST_SYNC1, ST_AM1, ST_IDAM, ST_ID, ST_IDCRC, ST_GAP2, ST_SYNC2,
    ST_AM2, ST_DAM, ST_DATA, ST_DCRC, ST_GAP3, ST_DONE
  } seg_e;

  localparam logic [7:0] GAP_BYTE  = 8'h4E;
  localparam logic [7:0] SYNC_BYTE = 8'h00;
  localparam logic [7:0] IXM_BYTE  = 8'hC2;
  localparam logic [7:0] IAM_BYTE  = 8'hFC;
  localparam logic [7:0] AM_BYTE   = 8'hA1;
  localparam logic [7:0] IDAM_BYTE = 8'hFE;
  localparam logic [7:0] DAM_BYTE  = 8'hFB;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/trk_fmt_crc.sv
module trk_fmt_crc
  import trk_fmt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        init_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= CRC_INIT;
    else if (en_i) crc_q <= crc_byte(init_i ? CRC_INIT : crc_q, data_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/trk_fmt_seq.sv
module trk_fmt_seq
  import trk_fmt_pkg::*;
#(
  parameter int unsigned HDR_GAP_LEN = 80,
  parameter int unsigned SYNC_LEN    = 12,
  parameter int unsigned GAP1_LEN    = 50,
  parameter int unsigned GAP2_LEN    = 22,
  parameter int unsigned MARK_LEN    = 3,
  parameter int unsigned MAX_SHIFT   = 7,
  localparam int unsigned CNT_W      = 8 + MAX_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       spt_i,
  input  logic [7:0]       gap3_i,
  input  logic [2:0]       n_code_i,
  input  logic             fire_i,
  input  logic             id_fire_i,
  output seg_e             seg_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [1:0]       id_idx_o,
  output logic             start_take_o
);
  seg_e             seg_q, seg_d;
  logic [CNT_W-1:0] cnt_q, seg_len;
  logic [1:0]       id_idx_q;
  logic [7:0]       sec_q, spt_q, gap_q;
  logic             last, sec_last, adv;
  seg_e             eos;

  assign start_take_o = start_i && (seg_q == ST_IDLE || seg_q == ST_DONE);

  always_comb begin
    case (seg_q)
      ST_HGAP:                       seg_len = CNT_W'(HDR_GAP_LEN);
      ST_HSYNC, ST_SYNC1, ST_SYNC2:  seg_len = CNT_W'(SYNC_LEN);
      ST_HMARK, ST_AM1, ST_AM2:      seg_len = CNT_W'(MARK_LEN);
      ST_HGAP1:                      seg_len = CNT_W'(GAP1_LEN);
      ST_GAP2:                       seg_len = CNT_W'(GAP2_LEN);
      ST_ID:                         seg_len = CNT_W'(4);
      ST_IDCRC, ST_DCRC:             seg_len = CNT_W'(2);
      ST_DATA:                       seg_len = CNT_W'(128) << n_code_i;
      ST_GAP3:                       seg_len = CNT_W'(gap_q);
      default:                       seg_len = CNT_W'(1);
    endcase
  end

  assign last     = (cnt_q == seg_len - CNT_W'(1));
  assign sec_last = ({1'b0, sec_q} + 9'd1) == {1'b0, spt_q};
  assign eos      = sec_last ? ST_DONE : ST_WAIT;

  // segment order; a zero trailing gap is skipped
  always_comb begin
    case (seg_q)
      ST_HGAP:  seg_d = ST_HSYNC;
      ST_HSYNC: seg_d = ST_HMARK;
      ST_HMARK: seg_d = ST_HIAM;
      ST_HIAM:  seg_d = ST_HGAP1;
      ST_HGAP1: seg_d = (spt_q == 8'd0) ? ST_DONE : ST_WAIT;
      ST_SYNC1: seg_d = ST_AM1;
      ST_AM1:   seg_d = ST_IDAM;
      ST_IDAM:  seg_d = ST_ID;
      ST_ID:    seg_d = ST_IDCRC;
      ST_IDCRC: seg_d = ST_GAP2;
      ST_GAP2:  seg_d = ST_SYNC2;
      ST_SYNC2: seg_d = ST_AM2;
      ST_AM2:   seg_d = ST_DAM;
      ST_DAM:   seg_d = ST_DATA;
      ST_DATA:  seg_d = ST_DCRC;
      ST_DCRC:  seg_d = (gap_q == 8'd0) ? eos : ST_GAP3;
      ST_GAP3:  seg_d = eos;
      default:  seg_d = seg_q;
    endcase
  end

  assign adv = fire_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q    <= ST_IDLE;
      cnt_q    <= '0;
      id_idx_q <= '0;
      sec_q    <= '0;
      spt_q    <= '0;
      gap_q    <= '0;
    end else if (start_take_o) begin
      seg_q    <= ST_HGAP;
      cnt_q    <= '0;
      id_idx_q <= '0;
      sec_q    <= '0;
      spt_q    <= spt_i;
      gap_q    <= gap3_i;
    end else if (seg_q == ST_WAIT) begin
      if (id_fire_i) begin
        id_idx_q <= id_idx_q + 2'd1;
        if (id_idx_q == 2'd3) begin
          seg_q <= ST_SYNC1;
          cnt_q <= '0;
        end
      end
    end else if (adv) begin
      seg_q <= seg_d;
      cnt_q <= '0;
      if ((seg_q == ST_DCRC && gap_q == 8'd0) || seg_q == ST_GAP3) sec_q <= sec_q + 8'd1;
    end else if (fire_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign seg_o    = seg_q;
  assign cnt_o    = cnt_q;
  assign id_idx_o = id_idx_q;
endmodule

// File: rtl/trk_fmt_gen.sv
module trk_fmt_gen
  import trk_fmt_pkg::*;
#(
  parameter int unsigned HDR_GAP_LEN = 80,
  parameter int unsigned SYNC_LEN    = 12,
  parameter int unsigned GAP1_LEN    = 50,
  parameter int unsigned GAP2_LEN    = 22,
  parameter int unsigned MARK_LEN    = 3,
  parameter int unsigned MAX_SHIFT   = 7,
  parameter int unsigned ID_BYTES    = 4,
  localparam int unsigned CNT_W      = 8 + MAX_SHIFT
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] spt_i,
  input  logic [7:0] gap3_i,
  input  logic [7:0] fill_i,
  input  logic       id_valid_i,
  input  logic [7:0] id_data_i,
  output logic       id_ready_o,
  output logic       out_valid_o,
  input  logic       out_ready_i,
  output logic [7:0] out_data_o,
  output logic       out_mark_o,
  output logic       done_o
);
  seg_e             seg;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       id_idx;
  logic             start_take, fire, id_fire, crc_en, crc_init;
  logic [15:0]      crc;
  logic [7:0]       fill_q;
  logic [7:0]       id_q [ID_BYTES];
  logic [7:0]       crc_sel;

  assign id_ready_o  = (seg == ST_WAIT);
  assign out_valid_o = !(seg == ST_IDLE || seg == ST_WAIT || seg == ST_DONE);
  assign done_o      = (seg == ST_DONE);
  assign fire        = out_valid_o && out_ready_i;
  assign id_fire     = id_valid_i && id_ready_o;

  trk_fmt_seq #(
    .HDR_GAP_LEN(HDR_GAP_LEN), .SYNC_LEN(SYNC_LEN), .GAP1_LEN(GAP1_LEN),
    .GAP2_LEN(GAP2_LEN), .MARK_LEN(MARK_LEN), .MAX_SHIFT(MAX_SHIFT)
  ) i_seq (
    .clk_i, .rst_ni, .start_i, .spt_i, .gap3_i,
    .n_code_i(id_q[ID_BYTES-1][2:0]),
    .fire_i(fire), .id_fire_i(id_fire),
    .seg_o(seg), .cnt_o(cnt), .id_idx_o(id_idx), .start_take_o(start_take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         fill_q <= '0;
    else if (start_take) fill_q <= fill_i;
  end

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             id_q[g] <= '0;
      else if (id_fire && id_idx == 2'(g))     id_q[g] <= id_data_i;
    end
  end

  // CRC regions start on the first mark byte and run through N / last fill byte
  assign crc_en = fire && (seg inside {ST_AM1, ST_IDAM, ST_ID, ST_AM2, ST_DAM, ST_DATA});
  assign crc_init = (seg == ST_AM1 || seg == ST_AM2) && cnt == '0;

  trk_fmt_crc i_crc (
    .clk_i, .rst_ni, .en_i(crc_en), .init_i(crc_init), .data_i(out_data_o), .crc_o(crc)
  );

  assign crc_sel = cnt[0] ? crc[7:0] : crc[15:8];

  always_comb begin
    out_mark_o = 1'b0;
    case (seg)
      ST_HSYNC, ST_SYNC1, ST_SYNC2: out_data_o = SYNC_BYTE;
      ST_HMARK: begin out_data_o = IXM_BYTE; out_mark_o = 1'b1; end
      ST_AM1, ST_AM2: begin out_data_o = AM_BYTE; out_mark_o = 1'b1; end
      ST_HIAM:  out_data_o = IAM_BYTE;
      ST_IDAM:  out_data_o = IDAM_BYTE;
      ST_DAM:   out_data_o = DAM_BYTE;
      ST_ID:    out_data_o = id_q[cnt[1:0]];
      ST_IDCRC, ST_DCRC: out_data_o = crc_sel;
      ST_DATA:  out_data_o = fill_q;
      default:  out_data_o = GAP_BYTE;
    endcase
  end
endmodule

// File: rtl/trk_fmt_gen_chk.sv
module trk_fmt_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       id_ready_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input logic       out_mark_o,
  input logic       done_o
);
  // R1
  always_ff @(posedge clk_i) begin
    if (!rst_ni) reset_quiet_chk: assert (!out_valid_o && !id_ready_o && !done_o);
  end

  // R2
  start_hdr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !out_valid_o && !id_ready_o) |=> (out_valid_o && out_data_o == 8'h4E));

  // R7
  mark_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_mark_o) |-> (out_data_o == 8'hA1 || out_data_o == 8'hC2));

  // R8
  id_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_ready_o |-> !out_valid_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_mark_o)));

  // R10
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!out_valid_o && !id_ready_o));
endmodule

bind trk_fmt_gen trk_fmt_gen_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .id_ready_o(id_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
  .out_mark_o(out_mark_o), .done_o(done_o)
);

// File: tb/test_trk_fmt_gen.sv
module test_trk_fmt_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [7:0] spt_i = '0, gap3_i = '0, fill_i = '0, id_data_i = '0;
  logic id_valid_i = 1'b0, out_ready_i = 1'b0;
  logic id_ready_o, out_valid_o, out_mark_o, done_o;
  logic [7:0] out_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  trk_fmt_gen i_trk_fmt_gen (
    .clk_i(clk), .rst_ni, .start_i, .spt_i, .gap3_i, .fill_i,
    .id_valid_i, .id_data_i, .id_ready_o, .out_valid_o, .out_ready_i,
    .out_data_o, .out_mark_o, .done_o
  );

  int n_checks = 0, n_err = 0;
  logic [7:0] exp_d[$], got_d[$];
  bit         exp_m[$], got_m[$];
  int         exp_r[$];
  logic [7:0] ids [0:15];

  function automatic logic [15:0] crc_upd(logic [15:0] c, logic [7:0] d);
    for (int i = 7; i >= 0; i--)
      c = (c[15] ^ d[i]) ? ((c << 1) ^ 16'h1021) : (c << 1);
    return c;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_b(logic [7:0] d, bit m, int r, int n);
    for (int i = 0; i < n; i++) begin
      exp_d.push_back(d); exp_m.push_back(m); exp_r.push_back(r);
    end
  endtask

  // regions: 2 preamble, 3 ID part, 4 data part, 5 trailing gap, 6 CRC bytes
  task automatic build(int spt, int gap, logic [7:0] fill);
    logic [15:0] c;
    exp_d.delete(); exp_m.delete(); exp_r.delete();
    push_b(8'h4E, 0, 2, 80); push_b(8'h00, 0, 2, 12); push_b(8'hC2, 1, 2, 3);
    push_b(8'hFC, 0, 2, 1);  push_b(8'h4E, 0, 2, 50);
    for (int s = 0; s < spt; s++) begin
      push_b(8'h00, 0, 3, 12);
      c = 16'hFFFF;
      for (int k = 0; k < 3; k++) c = crc_upd(c, 8'hA1);
      push_b(8'hA1, 1, 3, 3);
      c = crc_upd(c, 8'hFE); push_b(8'hFE, 0, 3, 1);
      for (int k = 0; k < 4; k++) begin
        c = crc_upd(c, ids[4*s+k]); push_b(ids[4*s+k], 0, 3, 1);
      end
      push_b(c[15:8], 0, 6, 1); push_b(c[7:0], 0, 6, 1);
      push_b(8'h4E, 0, 3, 22); push_b(8'h00, 0, 4, 12);
      c = 16'hFFFF;
      for (int k = 0; k < 3; k++) c = crc_upd(c, 8'hA1);
      push_b(8'hA1, 1, 4, 3);
      c = crc_upd(c, 8'hFB); push_b(8'hFB, 0, 4, 1);
      for (int k = 0; k < (128 << (ids[4*s+3] & 8'd7)); k++) c = crc_upd(c, fill);
      push_b(fill, 0, 4, 128 << (ids[4*s+3] & 8'd7));
      push_b(c[15:8], 0, 6, 1); push_b(c[7:0], 0, 6, 1);
      push_b(8'h4E, 0, 5, gap);
    end
  endtask

  task automatic run_track(int spt, int gap, logic [7:0] fill, int rdy_pct, bit disturb);
    int idx = 0, cyc = 0, hold_err = 0, r8_err = 0, merr = 0, mfa = 0, mfe = 0;
    int rerr[8], fa[8], fe[8];
    bit stall = 0, rdy;
    logic [7:0] sdata = '0;
    for (int i = 0; i < 8; i++) begin rerr[i] = 0; fa[i] = 0; fe[i] = 0; end
    build(spt, gap, fill);
    got_d.delete(); got_m.delete();
    spt_i = 8'(spt); gap3_i = 8'(gap); fill_i = fill; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; spt_i = 8'($urandom); gap3_i = 8'($urandom); fill_i = 8'($urandom);
    check(done_o == 1'b0, "R10 done cleared by start", done_o, 0);
    while (got_d.size() < exp_d.size() && cyc < 40000) begin
      rdy = ($urandom_range(99, 0) < rdy_pct);
      out_ready_i = rdy;
      if (stall && out_valid_o && out_data_o != sdata) hold_err++;
      if (out_valid_o && id_ready_o) r8_err++;
      if (out_valid_o && rdy) begin got_d.push_back(out_data_o); got_m.push_back(out_mark_o); end
      stall = out_valid_o && !rdy; sdata = out_data_o;
      if (id_ready_o) begin
        id_valid_i = $urandom_range(1, 0);
        id_data_i  = ids[idx];
        if (id_valid_i) idx++;
      end else begin
        id_valid_i = disturb;
        id_data_i  = 8'hEE;
      end
      if (disturb && cyc == 40) begin start_i = 1'b1; spt_i = 8'd9; end
      else start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    out_ready_i = 1'b0; id_valid_i = 1'b0; start_i = 1'b0;
    for (int i = 0; i < got_d.size() && i < exp_d.size(); i++) begin
      if (got_d[i] != exp_d[i]) begin
        if (rerr[exp_r[i]] == 0) begin fa[exp_r[i]] = got_d[i]; fe[exp_r[i]] = exp_d[i]; end
        rerr[exp_r[i]]++;
      end
      if (got_m[i] != exp_m[i]) begin
        if (merr == 0) begin mfa = got_m[i]; mfe = exp_m[i]; end
        merr++;
      end
    end
    check(got_d.size() == exp_d.size(), "R10 stream length", got_d.size(), exp_d.size());
    check(done_o == 1'b1 && out_valid_o == 1'b0, "R10 done after last sector", done_o, 1);
    check(rerr[2] == 0, "R2 preamble bytes", fa[2], fe[2]);
    check(rerr[3] == 0, "R3 ID field bytes", fa[3], fe[3]);
    check(rerr[4] == 0, "R4 data field bytes", fa[4], fe[4]);
    check(rerr[5] == 0, "R5 trailing gap bytes", fa[5], fe[5]);
    check(rerr[6] == 0, "R6 CRC bytes", fa[6], fe[6]);
    check(merr == 0, "R7 mark flag", mfa, mfe);
    check(r8_err == 0 && id_ready_o == 1'b0, "R8 ID ready only while waiting", r8_err, 0);
    check(hold_err == 0, "R9 byte held under stall", hold_err, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    int spt, gap, n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(out_valid_o == 0 && id_ready_o == 0 && done_o == 0, "R1 reset state",
          {out_valid_o, id_ready_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(out_valid_o == 0 && id_ready_o == 0 && done_o == 0, "R1 idle after reset",
          {out_valid_o, id_ready_o, done_o}, 0);
    // directed: two sectors, different sizes
    ids[0] = 8'h01; ids[1] = 8'h00; ids[2] = 8'h01; ids[3] = 8'h00;
    ids[4] = 8'h01; ids[5] = 8'h00; ids[6] = 8'h02; ids[7] = 8'h01;
    run_track(2, 5, 8'hE5, 100, 0);
    // zero trailing gap (R5), junk ID traffic and mid-track start (R8, R10)
    ids[0] = 8'h02; ids[1] = 8'h01; ids[2] = 8'h03; ids[3] = 8'h00;
    run_track(1, 0, 8'h00, 60, 1);
    // zero sector count (R10)
    run_track(0, 10, 8'h11, 100, 0);
    // size code above 7 is masked (R4)
    ids[0] = 8'h05; ids[1] = 8'h00; ids[2] = 8'h01; ids[3] = 8'h0A;
    run_track(1, 3, 8'h6C, 80, 1);
    // largest data field
    ids[0] = 8'h00; ids[1] = 8'h00; ids[2] = 8'h01; ids[3] = 8'h07;
    run_track(1, 1, 8'hA1, 100, 0);
    // constrained random tracks
    for (int t = 0; t < 5; t++) begin
      spt = $urandom_range(3, 1);
      gap = $urandom_range(30, 0);
      for (int s = 0; s < spt; s++) begin
        n = $urandom_range(2, 0);
        ids[4*s]   = 8'($urandom); ids[4*s+1] = 8'($urandom);
        ids[4*s+2] = 8'($urandom); ids[4*s+3] = 8'(n) | (8'($urandom) & 8'hF8);
      end
      run_track(spt, gap, 8'($urandom), $urandom_range(100, 50), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule